// File: doc/BRIEF.md
# Self-Refresh Dirty-Plane Tracker and Re-Arm Timer

This block sits beside the self-refresh sequencer of one display pipe. Rendering events arrive as invalidate or flush notices, each with a plane bitmask. The block keeps a mask of planes that are still being drawn into. It pulses an exit request when drawing means the panel must leave self-refresh. Once every plane of the pipe is clean again, it pulses an activate request after a deferred re-arm.

Re-arming is slow on purpose. A flush that leaves the busy mask empty while self-refresh is not active starts a delay counter, clocked by a one-millisecond tick. When the delay runs out, the block waits a bounded time for the sequencer to report idle. It then checks again that the feature is still on and that no plane went busy during the delay. Only then does it issue activate. Two tracking modes change the delays and decide whether page-flip flushes force an exit.

Events use a valid/ready handshake. `evt_ready` is held high, so the block never applies back-pressure: each cycle with `evt_valid` high delivers exactly one event.

Top module: `sr_rearm_ctrl`

## Requirements
- R1: Event plane masks are ANDed with the parameter `PIPE_PLANES` (default 8'h0F). Bits outside it never reach `busy_mask` and never cause an exit.
- R2: An accepted invalidate (`evt_is_flush`=0) ORs its masked bits into `busy_mask`. A nonzero masked value requests an exit.
- R3: An accepted flush (`evt_is_flush`=1) clears its masked bits from `busy_mask`.
- R4: A flush with nonzero masked bits requests an exit, with one exception. When `hw_track_mode`=1 and `evt_from_flip`=1, it does not. When `hw_track_mode`=0, flip flushes also request an exit.
- R5: `exit_req` is a one-cycle pulse in the cycle after the event is accepted. It is suppressed when `sr_active` is low at the event.
- R6: A flush taken with `sr_active` low that leaves `busy_mask` zero starts the re-arm delay. The delay is 100 ticks with `hw_track_mode`=1 and 500 with `hw_track_mode`=0; the mode is taken at start. The cycle after the last delay tick, the block starts waiting for `sr_idle`. `activate_req` pulses one cycle after `sr_idle` is seen high during that wait.
- R7: A qualifying flush that arrives while the delay is running restarts the full delay.
- R8: The idle wait times out after 50 ticks with `hw_track_mode`=1 and 1 tick with `hw_track_mode`=0. After a timeout no activate is issued.
- R9: Activate is issued only if `enable` is high and `busy_mask` is zero at the moment idle is seen. An invalidate during the delay therefore suppresses it.
- R10: With `enable` low, any pending delay or idle wait is cancelled. Events change neither `busy_mask` nor `exit_req`.
- R11: In the cycle after `enable` rises, `busy_mask` reads zero.
- R12: `evt_ready` is high whenever the block is out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Feature enable for this pipe |
| hw_track_mode | input | 1 | 1: hardware-tracking mode, 0: software-tracking mode |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| sr_active | input | 1 | Sequencer reports self-refresh active |
| sr_idle | input | 1 | Sequencer reports idle |
| evt_valid | input | 1 | Event present |
| evt_ready | output | 1 | Event accepted (always high) |
| evt_is_flush | input | 1 | 1: flush, 0: invalidate |
| evt_from_flip | input | 1 | Flush originates from a page flip |
| evt_planes | input | PLANES | Plane bitmask of the event |
| busy_mask | output | PLANES | Planes of this pipe still being drawn |
| exit_req | output | 1 | One-cycle exit request to the sequencer |
| activate_req | output | 1 | One-cycle activate request to the sequencer |

## Verification
The busy mask and `exit_req` are due one cycle after the edge that accepts an event. `activate_req` is due one cycle after the edge on which `sr_idle` is seen during the idle wait. That wait starts at the edge of the final delay tick, so with `sr_idle` already high the pulse follows that edge by one cycle. The bench tracks edges with a cycle counter and queues each expected pulse with the exact cycle it must appear in. A monitor samples on the falling edge and matches every pulse against the head of the queue. Any missing, early, late or unexpected pulse is therefore reported.

// File: rtl/sr_rearm_pkg.sv
package sr_rearm_pkg;
  typedef enum logic [1:0] {
    TMR_IDLE  = 2'd0,
    TMR_DELAY = 2'd1,
    TMR_WAIT  = 2'd2
  } tmr_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/plane_busy_unit.sv
module plane_busy_unit #(
  parameter int unsigned PLANES = 8,
  parameter logic [PLANES-1:0] PIPE_PLANES = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              hw_track_mode,
  input  logic              sr_active,
  input  logic              evt_valid,
  input  logic              evt_is_flush,
  input  logic              evt_from_flip,
  input  logic [PLANES-1:0] evt_planes,
  output logic [PLANES-1:0] busy_mask,
  output logic              exit_req,
  output logic              arm_start
);
  logic [PLANES-1:0] masked;
  logic              accept;
  logic              en_q;
  logic              en_rise;
  logic              wants_exit;

  assign masked  = evt_planes & PIPE_PLANES;
  assign accept  = evt_valid & enable;
  assign en_rise = enable & ~en_q;

  // Flip flushes are exempt only in hardware-tracking mode
  assign wants_exit = (|masked) & sr_active &
                      (~evt_is_flush | ~(hw_track_mode & evt_from_flip));

  // Re-arm starts when a flush leaves nothing busy while not in self-refresh
  assign arm_start = accept & evt_is_flush & ~sr_active &
                     ((busy_mask & ~masked) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_mask <= '0;
      exit_req  <= 1'b0;
      en_q      <= 1'b0;
    end else begin
      en_q     <= enable;
      exit_req <= accept & wants_exit;
      if (en_rise) begin
        busy_mask <= '0;
      end else if (accept) begin
        if (evt_is_flush) busy_mask <= busy_mask & ~masked;
        else              busy_mask <= busy_mask | masked;
      end
    end
  end
endmodule

// File: rtl/rearm_timer.sv
module rearm_timer
  import sr_rearm_pkg::*;
#(
  parameter int unsigned HW_DELAY_MS   = 100,
  parameter int unsigned SW_DELAY_MS   = 500,
  parameter int unsigned HW_IDLE_TO_MS = 50,
  parameter int unsigned SW_IDLE_TO_MS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic hw_track_mode,
  input  logic ms_tick,
  input  logic start,
  input  logic sr_idle,
  input  logic busy_zero,
  output logic activate_req
);
  localparam int unsigned MAX_DLY = max2(HW_DELAY_MS, SW_DELAY_MS);
  localparam int unsigned MAX_TO  = max2(HW_IDLE_TO_MS, SW_IDLE_TO_MS);
  localparam int unsigned MAX_CNT = max2(MAX_DLY, MAX_TO);
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

  tmr_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             mode_q;
  logic             last_tick;

  assign last_tick = ms_tick & (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= TMR_IDLE;
      cnt          <= '0;
      mode_q       <= 1'b0;
      activate_req <= 1'b0;
    end else begin
      activate_req <= 1'b0;
      if (!enable) begin
        state <= TMR_IDLE;
      end else if (start) begin
        state  <= TMR_DELAY;
        mode_q <= hw_track_mode;
        cnt    <= hw_track_mode ? CNT_W'(HW_DELAY_MS) : CNT_W'(SW_DELAY_MS);
      end else begin
        unique case (state)
          TMR_DELAY: begin
            if (last_tick) begin
              state <= TMR_WAIT;
              cnt   <= mode_q ? CNT_W'(HW_IDLE_TO_MS) : CNT_W'(SW_IDLE_TO_MS);
            end else if (ms_tick) begin
              cnt <= cnt - CNT_W'(1);
            end
          end
          TMR_WAIT: begin
            if (sr_idle) begin
              state        <= TMR_IDLE;
              activate_req <= busy_zero;
            end else if (last_tick) begin
              state <= TMR_IDLE;
            end else if (ms_tick) begin
              cnt <= cnt - CNT_W'(1);
            end
          end
          default: state <= TMR_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sr_rearm_ctrl.sv
module sr_rearm_ctrl #(
  parameter int unsigned       PLANES        = 8,
  parameter logic [PLANES-1:0] PIPE_PLANES   = 8'h0F,
  parameter int unsigned       HW_DELAY_MS   = 100,
  parameter int unsigned       SW_DELAY_MS   = 500,
  parameter int unsigned       HW_IDLE_TO_MS = 50,
  parameter int unsigned       SW_IDLE_TO_MS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              hw_track_mode,
  input  logic              ms_tick,
  input  logic              sr_active,
  input  logic              sr_idle,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic              evt_is_flush,
  input  logic              evt_from_flip,
  input  logic [PLANES-1:0] evt_planes,
  output logic [PLANES-1:0] busy_mask,
  output logic              exit_req,
  output logic              activate_req
);
  logic arm_start;

  // No back-pressure: one event per valid cycle
  assign evt_ready = 1'b1;

  plane_busy_unit #(
    .PLANES      (PLANES),
    .PIPE_PLANES (PIPE_PLANES)
  ) u_busy (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .hw_track_mode (hw_track_mode),
    .sr_active     (sr_active),
    .evt_valid     (evt_valid),
    .evt_is_flush  (evt_is_flush),
    .evt_from_flip (evt_from_flip),
    .evt_planes    (evt_planes),
    .busy_mask     (busy_mask),
    .exit_req      (exit_req),
    .arm_start     (arm_start)
  );

  rearm_timer #(
    .HW_DELAY_MS   (HW_DELAY_MS),
    .SW_DELAY_MS   (SW_DELAY_MS),
    .HW_IDLE_TO_MS (HW_IDLE_TO_MS),
    .SW_IDLE_TO_MS (SW_IDLE_TO_MS)
  ) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .hw_track_mode (hw_track_mode),
    .ms_tick       (ms_tick),
    .start         (arm_start),
    .sr_idle       (sr_idle),
    .busy_zero     (busy_mask == '0),
    .activate_req  (activate_req)
  );
endmodule

// File: rtl/sr_rearm_ctrl_chk.sv
module sr_rearm_ctrl_chk #(
  parameter int unsigned       PLANES      = 8,
  parameter logic [PLANES-1:0] PIPE_PLANES = 8'h0F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              sr_active,
  input logic              evt_valid,
  input logic [PLANES-1:0] busy_mask,
  input logic              exit_req,
  input logic              activate_req
);
  assert_pipe_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_mask & ~PIPE_PLANES) == '0);

  assert_exit_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> ($past(sr_active) && $past(evt_valid)));

  assert_act_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    activate_req |-> ($past(enable) && ($past(busy_mask) == '0)));

  assert_off_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> $stable(busy_mask));

  assert_off_no_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !exit_req);
endmodule

bind sr_rearm_ctrl sr_rearm_ctrl_chk #(
  .PLANES      (PLANES),
  .PIPE_PLANES (PIPE_PLANES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .sr_active    (sr_active),
  .evt_valid    (evt_valid),
  .busy_mask    (busy_mask),
  .exit_req     (exit_req),
  .activate_req (activate_req)
);

// File: tb/test_sr_rearm_ctrl.sv
`timescale 1ns/1ps
module test_sr_rearm_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       hw_track_mode = 1'b1;
  logic       ms_tick = 1'b0;
  logic       sr_active = 1'b0;
  logic       sr_idle = 1'b0;
  logic       evt_valid = 1'b0;
  logic       evt_ready;
  logic       evt_is_flush = 1'b0;
  logic       evt_from_flip = 1'b0;
  logic [7:0] evt_planes = 8'h00;
  logic [7:0] busy_mask;
  logic       exit_req;
  logic       activate_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    bit    kind;   // 0 exit, 1 activate
    int    when;
    string req;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sr_rearm_ctrl i_sr_rearm_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hw_track_mode(hw_track_mode),
    .ms_tick(ms_tick), .sr_active(sr_active), .sr_idle(sr_idle),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_is_flush(evt_is_flush),
    .evt_from_flip(evt_from_flip), .evt_planes(evt_planes),
    .busy_mask(busy_mask), .exit_req(exit_req), .activate_req(activate_req)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_pulse(input bit kind, input int when, input string req);
    exp_t e;
    e.kind = kind; e.when = when; e.req = req;
    q.push_back(e);
  endtask

  task automatic take(input bit kind);
    exp_t e;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL %s unexpected %s pulse: actual cycle %0d expected none",
               kind ? "R9" : "R5", kind ? "activate" : "exit", cyc);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.when != cyc) begin
        errors++;
        $display("FAIL %s pulse: actual kind %0d cycle %0d expected kind %0d cycle %0d",
                 e.req, kind, cyc, e.kind, e.when);
      end
    end
  endtask

  // Monitor: samples away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (exit_req)     take(1'b0);
      if (activate_req) take(1'b1);
    end
  end

  task automatic send(input bit flush, input bit flip, input logic [7:0] planes,
                      input bit exp_exit, input string req);
    @(negedge clk);
    evt_valid = 1'b1; evt_is_flush = flush; evt_from_flip = flip; evt_planes = planes;
    if (exp_exit) expect_pulse(1'b0, cyc + 1, req);
    @(negedge clk);
    evt_valid = 1'b0; evt_from_flip = 1'b0; evt_planes = 8'h00;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk);
      ms_tick = 1'b1;
    end
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic raise_idle_expect(input string req);
    @(negedge clk);
    @(negedge clk);
    sr_idle = 1'b1;
    expect_pulse(1'b1, cyc + 1, req);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R12", "reset ready", evt_ready, 1);
    check_eq("R2", "reset busy", busy_mask, 0);
    check_eq("R5", "reset exit", exit_req, 0);
    check_eq("R6", "reset activate", activate_req, 0);
    rst_n = 1'b1;
    @(negedge clk); enable = 1'b1;
    @(negedge clk);
    check_eq("R12", "ready after reset", evt_ready, 1);

    // R1: other pipe's planes only
    sr_active = 1'b1;
    send(1'b0, 1'b0, 8'h30, 1'b0, "R1");
    check_eq("R1", "foreign planes", busy_mask, 8'h00);
    // R2: invalidate sets and exits
    send(1'b0, 1'b0, 8'h35, 1'b1, "R2");
    check_eq("R2", "invalidate busy", busy_mask, 8'h05);
    // R5: not active, no exit
    sr_active = 1'b0;
    send(1'b0, 1'b0, 8'h02, 1'b0, "R5");
    check_eq("R5", "busy after quiet invalidate", busy_mask, 8'h07);
    // R4 / R3: flip flush in hardware mode, no exit
    sr_active = 1'b1;
    send(1'b1, 1'b1, 8'h01, 1'b0, "R4");
    check_eq("R3", "flip flush clears", busy_mask, 8'h06);
    send(1'b1, 1'b0, 8'h02, 1'b1, "R4");
    check_eq("R3", "flush clears", busy_mask, 8'h04);

    // R6: hardware delay 100
    sr_active = 1'b0; sr_idle = 1'b1;
    send(1'b1, 1'b0, 8'h04, 1'b0, "R6");
    check_eq("R6", "busy empty", busy_mask, 8'h00);
    ticks(99);
    ticks(1);
    expect_pulse(1'b1, cyc + 1, "R6");
    idle_cycles(3);

    // R7: restart on second flush
    send(1'b1, 1'b0, 8'h01, 1'b0, "R7");
    ticks(50);
    send(1'b1, 1'b0, 8'h01, 1'b0, "R7");
    ticks(99);
    ticks(1);
    expect_pulse(1'b1, cyc + 1, "R7");
    idle_cycles(3);

    // R9: invalidate during delay blocks activate
    send(1'b1, 1'b0, 8'h01, 1'b0, "R9");
    ticks(60);
    send(1'b0, 1'b0, 8'h01, 1'b0, "R9");
    ticks(40);
    idle_cycles(3);
    check_eq("R9", "busy kept", busy_mask, 8'h01);

    // R8: hardware idle wait, success just before timeout
    sr_idle = 1'b0;
    send(1'b1, 1'b0, 8'h01, 1'b0, "R8");
    ticks(100);
    ticks(49);
    raise_idle_expect("R8");
    idle_cycles(3);
    // R8: hardware timeout
    sr_idle = 1'b0;
    send(1'b1, 1'b0, 8'h01, 1'b0, "R8");
    ticks(100);
    ticks(50);
    sr_idle = 1'b1;
    idle_cycles(5);

    // R4: software mode, flip flush exits
    hw_track_mode = 1'b0; sr_active = 1'b1;
    send(1'b0, 1'b0, 8'h01, 1'b1, "R2");
    send(1'b1, 1'b1, 8'h01, 1'b1, "R4");
    check_eq("R3", "sw flip flush clears", busy_mask, 8'h00);
    // R6: software delay 500
    sr_active = 1'b0;
    send(1'b0, 1'b0, 8'h01, 1'b0, "R5");
    send(1'b1, 1'b0, 8'h01, 1'b0, "R6");
    ticks(499);
    ticks(1);
    expect_pulse(1'b1, cyc + 1, "R6");
    idle_cycles(3);
    // R8: software timeout after 1 tick
    sr_idle = 1'b0;
    send(1'b1, 1'b0, 8'h01, 1'b0, "R8");
    ticks(500);
    ticks(1);
    sr_idle = 1'b1;
    idle_cycles(5);
    // R8: software wait success with no tick
    sr_idle = 1'b0;
    send(1'b1, 1'b0, 8'h01, 1'b0, "R8");
    ticks(500);
    raise_idle_expect("R8");
    idle_cycles(3);

    // R10 / R11: disable cancels, events ignored, enable clears
    hw_track_mode = 1'b1;
    send(1'b1, 1'b0, 8'h01, 1'b0, "R10");
    ticks(50);
    send(1'b0, 1'b0, 8'h03, 1'b0, "R10");
    check_eq("R2", "busy before disable", busy_mask, 8'h03);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); sr_active = 1'b1;
    send(1'b0, 1'b0, 8'h0C, 1'b0, "R10");
    check_eq("R10", "invalidate ignored", busy_mask, 8'h03);
    send(1'b1, 1'b0, 8'h03, 1'b0, "R10");
    check_eq("R10", "flush ignored", busy_mask, 8'h03);
    @(negedge clk); enable = 1'b1;
    @(negedge clk);
    check_eq("R11", "busy cleared on enable", busy_mask, 8'h00);
    sr_active = 1'b0;
    ticks(120);
    idle_cycles(5);

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s missing pulse: actual none expected cycle %0d", q[0].req, q[0].when);
    end
    summary();
  end
endmodule